// File: doc/BRIEF.md
# DSP Shifter with Overflow Flags

This block is the shift stage of a DSP datapath. In one operation it shifts a single 16-bit half, two packed 16-bit halves, a full 32-bit word or a 40-bit accumulator. A signed shift count chooses the direction. Zero or a negative count shifts right by its magnitude, and a positive count shifts left. The count comes from the low bits of a count register, or, for the 16-bit forms, from a short immediate that has its own encoding.

Left shifts of 16-bit and 32-bit data can saturate on request. They report a change of sign through an overflow flag and a sticky copy of that flag. Accumulator shifts come in an arithmetic variant and a logical variant. Both return the 40-bit result as an 8-bit extension and a 32-bit low word. Both also signal that the overflow flag of the chosen accumulator must be cleared. All results and flags are registered, and they appear one cycle after an input strobe together with an output strobe.

Top module: `dsp_shifter`

## Requirements
- R1: The register count `shift_cnt` is a 6-bit two's-complement value. A value from -32 to 0 gives a right shift by its magnitude, and a value from 1 to 31 gives a left shift by that amount.
- R2: For the immediate forms (op 5 and op 6), an `imm` above 16 gives a left shift by 16 minus `imm[3:0]`. An `imm` from 0 to 16 gives an arithmetic right shift by `imm`.
- R3: The half forms (op 0 with the register count, op 5 with the immediate) shift `operand[15:0]` and place the result in `result[15:0]`, with `result[31:16]` zero. Right shifts of 16-bit and 32-bit data fill with the sign bit.
- R4: On a left shift of 16-bit or 32-bit data, `flag_v` is 1 exactly when bit 15 (or bit 31) of the result before any clamping differs from that bit of the operand. A right shift leaves `flag_v` at 0.
- R5: The vector forms (op 1 with the register count, op 6 with the immediate) shift both halves of `operand` by the same amount, each on its own. `flag_v` is 1 if either half's sign bit changes.
- R6: With `sat`=1, a 16-bit or 32-bit left shift whose exact result falls outside the signed range of its width is clamped to the most positive value (operand sign 0) or the most negative value (operand sign 1). `flag_v` still follows R4.
- R7: The arithmetic accumulator shift (op 3) sign-extends `acc_in` from bit 39. It shifts by the register count and never saturates. It returns bits 39:32 on `acc_ext` and bits 31:0 on `acc_low`.
- R8: The logical accumulator shift (op 4) zero-fills on right shifts. Otherwise it behaves as in R7.
- R9: An accumulator shift pulses `av_clr` with `av_idx` equal to `acc_sel`, sets `flag_v` to 0 and drives `result` to 0. `sat` has no effect on it. Non-accumulator operations drive `acc_ext` and `acc_low` to 0.
- R10: `flag_vs` becomes 1 whenever an operation produces `flag_v`=1. It stays at 1 until `vs_clr` clears it. If a clear and an overflowing operation come in the same cycle, the flag ends up set.
- R11: The outputs take their new values on the clock edge that samples `in_valid`=1, and `out_valid` is high for exactly that cycle. Without `in_valid`, `result`, `acc_ext`, `acc_low` and `flag_v` hold their values.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation: 0 half/reg, 1 vector/reg, 2 word/reg, 3 acc arith, 4 acc logical, 5 half/imm, 6 vector/imm |
| sat | input | 1 | Saturate 16/32-bit left shifts |
| acc_sel | input | 1 | Accumulator number for the overflow clear |
| operand | input | 32 | 16-bit, packed or 32-bit data |
| acc_in | input | 40 | Accumulator value |
| shift_cnt | input | 6 | Signed register count |
| imm | input | 5 | Immediate count for ops 5 and 6 |
| vs_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Shifted 16-bit, packed or 32-bit result |
| acc_ext | output | 8 | Accumulator result bits 39:32 |
| acc_low | output | 32 | Accumulator result bits 31:0 |
| flag_v | output | 1 | Overflow of the last operation |
| flag_vs | output | 1 | Sticky overflow |
| av_clr | output | 1 | Pulse: clear the selected accumulator overflow flag |
| av_idx | output | 1 | Accumulator whose flag is cleared |

## Verification
The hardest cases to reach are left shifts that lose significant bits while keeping the sign. For example, 0x0100 shifted left by 8 wraps to zero. Saturation must then clamp while `flag_v` stays low, so the check separates the two mechanisms. The stimulus sweeps all 64 register counts and all 32 immediates over operands whose leading one sits at many positions, so both the sign-changing and the sign-preserving losses occur at every width. A separate sequence drives `vs_clr` in the same cycle as an overflowing shift, and again with no operation, to check which of the two wins.

// File: rtl/dsp_shift_pkg.sv
package dsp_shift_pkg;
   typedef enum logic [2:0] {
      OP_HALF_REG  = 3'd0,
      OP_VEC_REG   = 3'd1,
      OP_WORD_REG  = 3'd2,
      OP_ACC_ARITH = 3'd3,
      OP_ACC_LOGIC = 3'd4,
      OP_HALF_IMM  = 3'd5,
      OP_VEC_IMM   = 3'd6,
      OP_IDLE      = 3'd7
   } shift_op_e;
endpackage

// File: rtl/shift_count_decode.sv
module shift_count_decode #(
   parameter int CNT_W  = 6,
   parameter int HALF_W = 16,
   parameter int IMM_W  = 5
) (
   input  logic [CNT_W-1:0] cnt_raw,
   input  logic [IMM_W-1:0] imm,
   input  logic             use_imm,
   output logic             left,
   output logic [CNT_W-1:0] amt
);
   localparam logic [IMM_W-1:0] IMM_LIMIT = IMM_W'(HALF_W);
   localparam logic [CNT_W-1:0] AMT_HALF  = CNT_W'(HALF_W);

   if (HALF_W >= 2 ** (CNT_W - 1)) begin : g_bad_cnt
      $error("shift_count_decode: CNT_W too small for HALF_W");
   end
   if (IMM_W < 2) begin : g_bad_imm
      $error("shift_count_decode: IMM_W must be at least 2");
   end

   logic signed [CNT_W-1:0] cnt_s;
   logic        [CNT_W-1:0] neg_cnt;

   always_comb begin
      cnt_s   = signed'(cnt_raw);
      neg_cnt = CNT_W'(-cnt_s);
      if (use_imm) begin
         if (imm > IMM_LIMIT) begin
            left = 1'b1;
            amt  = AMT_HALF - CNT_W'(imm[IMM_W-2:0]);
         end else begin
            left = 1'b0;
            amt  = CNT_W'(imm);
         end
      end else if (cnt_s > 0) begin
         left = 1'b1;
         amt  = cnt_raw;
      end else begin
         left = 1'b0;
         amt  = neg_cnt;
      end
   end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
   parameter int W      = 16,
   parameter int AMT_W  = 6,
   parameter bit SAT_OK = 1'b1
) (
   input  logic [W-1:0]     val,
   input  logic             left,
   input  logic [AMT_W-1:0] amt,
   input  logic             arith,
   input  logic             sat_en,
   output logic [W-1:0]     res,
   output logic             ovf,
   output logic             clamped
);
   localparam int XW = W + 2 ** (AMT_W - 1) + 1;
   localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

   if (W < 2) begin : g_bad_w
      $error("lane_shifter: W must be at least 2");
   end

   logic [XW-1:0] ext;
   logic [XW-1:0] shl;
   logic [XW-1:0] shr;
   logic [W-1:0]  wrapped;
   logic          lost;
   logic [W-1:0]  plain;

   always_comb begin
      ext     = arith ? {{(XW-W){val[W-1]}}, val} : {{(XW-W){1'b0}}, val};
      shl     = ext << amt;
      shr     = ext >> amt;
      wrapped = shl[W-1:0];
      lost    = !((&shl[XW-1:W-1]) || !(|shl[XW-1:W-1]));
      plain   = left ? wrapped : shr[W-1:0];
      ovf     = left && (wrapped[W-1] != val[W-1]);
   end

   logic unused_hi;
   assign unused_hi = ^shr[XW-1:W];

   if (SAT_OK) begin : g_sat
      always_comb begin
         clamped = left && sat_en && lost;
         res     = clamped ? (val[W-1] ? NEG_MAX : POS_MAX) : plain;
      end
   end else begin : g_nosat
      logic unused_sat;
      assign unused_sat = sat_en ^ lost;
      assign clamped    = 1'b0;
      assign res        = plain;
   end
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
   import dsp_shift_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 40,
   parameter int CNT_W  = 6,
   parameter int IMM_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [2:0]              op,
   input  logic                    sat,
   input  logic                    acc_sel,
   input  logic [DATA_W-1:0]       operand,
   input  logic [ACC_W-1:0]        acc_in,
   input  logic [CNT_W-1:0]        shift_cnt,
   input  logic [IMM_W-1:0]        imm,
   input  logic                    vs_clr,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       result,
   output logic [ACC_W-DATA_W-1:0] acc_ext,
   output logic [DATA_W-1:0]       acc_low,
   output logic                    flag_v,
   output logic                    flag_vs,
   output logic                    av_clr,
   output logic                    av_idx
);
   localparam int HALF_W  = DATA_W / 2;
   localparam int N_LANES = 2;
   localparam int EXT_W   = ACC_W - DATA_W;

   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("dsp_shifter: DATA_W must be even");
   end
   if (ACC_W <= DATA_W) begin : g_bad_acc
      $error("dsp_shifter: ACC_W must exceed DATA_W");
   end
   if (IMM_W != $clog2(HALF_W) + 1) begin : g_bad_immw
      $error("dsp_shifter: IMM_W must equal clog2(DATA_W/2)+1");
   end

   shift_op_e op_e;
   logic      use_imm;
   logic      left;
   logic [CNT_W-1:0] amt;

   assign op_e    = shift_op_e'(op);
   assign use_imm = (op_e == OP_HALF_IMM) || (op_e == OP_VEC_IMM);

   shift_count_decode #(
      .CNT_W (CNT_W),
      .HALF_W(HALF_W),
      .IMM_W (IMM_W)
   ) u_dec (
      .cnt_raw(shift_cnt),
      .imm    (imm),
      .use_imm(use_imm),
      .left   (left),
      .amt    (amt)
   );

   logic [HALF_W-1:0] lane_res [N_LANES];
   logic [N_LANES-1:0] lane_ovf;
   logic [N_LANES-1:0] lane_clamp;

   for (genvar i = 0; i < N_LANES; i++) begin : g_half
      lane_shifter #(
         .W     (HALF_W),
         .AMT_W (CNT_W),
         .SAT_OK(1'b1)
      ) u_lane (
         .val    (operand[i*HALF_W +: HALF_W]),
         .left   (left),
         .amt    (amt),
         .arith  (1'b1),
         .sat_en (sat),
         .res    (lane_res[i]),
         .ovf    (lane_ovf[i]),
         .clamped(lane_clamp[i])
      );
   end

   logic [DATA_W-1:0] word_res;
   logic              word_ovf;
   logic              word_clamp;

   lane_shifter #(
      .W     (DATA_W),
      .AMT_W (CNT_W),
      .SAT_OK(1'b1)
   ) u_word (
      .val    (operand),
      .left   (left),
      .amt    (amt),
      .arith  (1'b1),
      .sat_en (sat),
      .res    (word_res),
      .ovf    (word_ovf),
      .clamped(word_clamp)
   );

   logic [ACC_W-1:0] acc_res;
   logic             acc_ovf;
   logic             acc_clamp;

   lane_shifter #(
      .W     (ACC_W),
      .AMT_W (CNT_W),
      .SAT_OK(1'b0)
   ) u_acc (
      .val    (acc_in),
      .left   (left),
      .amt    (amt),
      .arith  (op_e == OP_ACC_ARITH),
      .sat_en (sat),
      .res    (acc_res),
      .ovf    (acc_ovf),
      .clamped(acc_clamp)
   );

   logic unused_flags;
   assign unused_flags = acc_ovf ^ acc_clamp ^ word_clamp ^ (^lane_clamp);

   logic [DATA_W-1:0] res_d;
   logic [EXT_W-1:0]  ext_d;
   logic [DATA_W-1:0] low_d;
   logic              v_d;
   logic              is_acc;

   always_comb begin
      res_d  = '0;
      ext_d  = '0;
      low_d  = '0;
      v_d    = 1'b0;
      is_acc = 1'b0;
      case (op_e)
         OP_HALF_REG, OP_HALF_IMM: begin
            res_d = {{HALF_W{1'b0}}, lane_res[0]};
            v_d   = lane_ovf[0];
         end
         OP_VEC_REG, OP_VEC_IMM: begin
            res_d = {lane_res[1], lane_res[0]};
            v_d   = |lane_ovf;
         end
         OP_WORD_REG: begin
            res_d = word_res;
            v_d   = word_ovf;
         end
         OP_ACC_ARITH, OP_ACC_LOGIC: begin
            ext_d  = acc_res[ACC_W-1:DATA_W];
            low_d  = acc_res[DATA_W-1:0];
            is_acc = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         acc_ext   <= '0;
         acc_low   <= '0;
         flag_v    <= 1'b0;
         flag_vs   <= 1'b0;
         av_clr    <= 1'b0;
         av_idx    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         av_clr    <= in_valid && is_acc;
         if (in_valid) begin
            result  <= res_d;
            acc_ext <= ext_d;
            acc_low <= low_d;
            flag_v  <= v_d;
            if (is_acc) av_idx <= acc_sel;
         end
         if (in_valid && v_d) flag_vs <= 1'b1;
         else if (vs_clr)     flag_vs <= 1'b0;
      end
   end

   // R11: output strobe follows the input strobe by one cycle
   a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(flag_v)));
   // R10: sticky flag only falls on an explicit clear
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_vs && !vs_clr) |=> flag_vs);
   a_r10_v_sets_vs: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flag_v) |-> flag_vs);
   // R9: accumulator operations never report overflow
   a_r9_acc_no_v: assert property (@(posedge clk) disable iff (!rst_n)
      av_clr |-> (out_valid && !flag_v && result == '0));
   // R3: half forms leave the upper half zero
   a_r3_half_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == OP_HALF_REG || op == OP_HALF_IMM))
      |=> (result[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/dsp_shifter_test.sv
`timescale 1ns/1ps
module dsp_shifter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'd7;
   logic        sat = 1'b0;
   logic        acc_sel = 1'b0;
   logic [31:0] operand = '0;
   logic [39:0] acc_in = '0;
   logic [5:0]  shift_cnt = '0;
   logic [4:0]  imm = '0;
   logic        vs_clr = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic [7:0]  acc_ext;
   logic [31:0] acc_low;
   logic        flag_v, flag_vs, av_clr, av_idx;

   int checks = 0;
   int errors = 0;
   bit exp_vs = 0;

   always #2 clk = ~clk;

   dsp_shifter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sat(sat),
      .acc_sel(acc_sel), .operand(operand), .acc_in(acc_in),
      .shift_cnt(shift_cnt), .imm(imm), .vs_clr(vs_clr),
      .out_valid(out_valid), .result(result), .acc_ext(acc_ext),
      .acc_low(acc_low), .flag_v(flag_v), .flag_vs(flag_vs),
      .av_clr(av_clr), .av_idx(av_idx)
   );

   logic [15:0] hpat [10] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
                              16'h4000, 16'hC001, 16'h1234, 16'h0100, 16'hA5A5};
   logic [31:0] wpat [8]  = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h0001_0000, 32'hC000_0003, 32'h1234_5678};
   logic [39:0] apat [6]  = '{40'h00_0000_0001, 40'h80_0000_0000, 40'hFF_FFFF_FFFF,
                              40'h7F_FFFF_FFFF, 40'h12_3456_789A, 40'h00_8000_0000};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h (op=%0d cnt=%0d imm=%0d sat=%0b opnd=%h acc=%h)",
                  req, act, exp, op, shift_cnt, imm, sat, operand, acc_in);
      end
   endtask

   function automatic void lane_ref(input longint val, input int w, input bit left,
                                    input int n, input bit arith, input bit sat_on,
                                    output longint res, output bit ovf);
      longint mask, sv, p, wrapped, mx, mn;
      mask = (longint'(1) << w) - 1;
      sv   = (arith && val[w-1]) ? (val | ~mask) : val;
      if (!left) begin
         res = (sv >>> n) & mask;
         ovf = 1'b0;
      end else begin
         p       = sv << n;
         wrapped = p & mask;
         ovf     = wrapped[w-1] != val[w-1];
         mx      = (longint'(1) << (w - 1)) - 1;
         mn      = -(longint'(1) << (w - 1));
         if (sat_on && (p > mx || p < mn)) res = (sv < 0 ? mn : mx) & mask;
         else res = wrapped;
      end
   endfunction

   // Drives one operation (at a negative edge) and checks it at the next negative edge.
   task automatic run(input int o, input bit s, input logic [31:0] d, input logic [39:0] a,
                      input logic [5:0] c, input logic [4:0] im, input bit asel, input bit clr);
      bit left, v0, v1, ev, isacc;
      int n, sc;
      longint r0, r1, er, ea;
      string tag;
      if (o == 5 || o == 6) begin
         left = im > 16;
         n    = left ? 16 - int'(im[3:0]) : int'(im);
         tag  = "R2";
      end else begin
         sc   = (c >= 32) ? int'(c) - 64 : int'(c);
         left = sc > 0;
         n    = left ? sc : -sc;
         tag  = "R1";
      end
      er = 0; ea = 0; ev = 0; isacc = 0;
      case (o)
         0, 5: begin lane_ref(longint'(d[15:0]), 16, left, n, 1, s, r0, v0);
                  er = r0; ev = v0; end
         1, 6: begin lane_ref(longint'(d[15:0]), 16, left, n, 1, s, r0, v0);
                  lane_ref(longint'(d[31:16]), 16, left, n, 1, s, r1, v1);
                  er = (r1 << 16) | r0; ev = v0 | v1; end
         2:    begin lane_ref(longint'(d), 32, left, n, 1, s, r0, v0);
                  er = r0; ev = v0; end
         3:    begin lane_ref(longint'(a), 40, left, n, 1, 0, ea, v0); isacc = 1; end
         4:    begin lane_ref(longint'(a), 40, left, n, 0, 0, ea, v0); isacc = 1; end
         default: ;
      endcase
      op = 3'(o); sat = s; operand = d; acc_in = a; shift_cnt = c; imm = im;
      acc_sel = asel; vs_clr = clr; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; vs_clr = 1'b0;
      if (ev) exp_vs = 1'b1;
      else if (clr) exp_vs = 1'b0;
      chk("R11 out_valid", 64'(out_valid), 64'd1);
      case (o)
         0, 5: chk({tag, " R3 R6 half result"}, 64'(result), 64'(er));
         1, 6: chk({tag, " R5 R6 vector result"}, 64'(result), 64'(er));
         2:    chk({tag, " R6 word result"}, 64'(result), 64'(er));
         3:    chk("R7 acc arith ext:low", {24'd0, acc_ext, acc_low}, 64'(ea));
         4:    chk("R8 acc logic ext:low", {24'd0, acc_ext, acc_low}, 64'(ea));
         default: ;
      endcase
      if (isacc) begin
         chk("R9 acc result zero", 64'(result), 64'd0);
         chk("R9 av_clr", 64'(av_clr), 64'd1);
         chk("R9 av_idx", 64'(av_idx), 64'(asel));
      end else begin
         chk("R9 acc outputs zero", {24'd0, acc_ext, acc_low}, 64'd0);
         chk("R9 no av_clr", 64'(av_clr), 64'd0);
      end
      chk(isacc ? "R9 flag_v" : (o == 1 || o == 6) ? "R5 flag_v" : "R4 flag_v",
          64'(flag_v), 64'(ev));
      chk("R10 flag_vs", 64'(flag_vs), 64'(exp_vs));
   endtask

   initial begin : watchdog
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] hold_res;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 reset out_valid", 64'(out_valid), 64'd0);
      chk("R12 reset result", 64'(result), 64'd0);
      chk("R12 reset acc", {24'd0, acc_ext, acc_low}, 64'd0);
      chk("R12 reset flags", {60'd0, flag_v, flag_vs, av_clr, av_idx}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4 R6: half form, every register count
      for (int p = 0; p < 10; p++)
         for (int c = 0; c < 64; c++)
            for (int s = 0; s < 2; s++)
               run(0, s[0], {16'hDEAD, hpat[p]}, '0, 6'(c), '0, 0, 0);
      // R5: vector form, mixed halves
      for (int p = 0; p < 10; p++)
         for (int c = 0; c < 64; c++)
            for (int s = 0; s < 2; s++)
               run(1, s[0], {hpat[(p + 3) % 10], hpat[p]}, '0, 6'(c), '0, 0, 0);
      // R4 R6: word form
      for (int p = 0; p < 8; p++)
         for (int c = 0; c < 64; c++)
            for (int s = 0; s < 2; s++)
               run(2, s[0], wpat[p], '0, 6'(c), '0, 0, 0);
      // R7 R8 R9: accumulator forms, sat must not matter
      for (int p = 0; p < 6; p++)
         for (int c = 0; c < 64; c++) begin
            run(3, c[0], 32'hFFFF_FFFF, apat[p], 6'(c), '0, c[1], 0);
            run(4, c[1], 32'h8000_0000, apat[p], 6'(c), '0, c[0], 0);
         end
      // R2: immediate forms, every immediate
      for (int p = 0; p < 10; p++)
         for (int i = 0; i < 32; i++) begin
            run(5, i[0], {16'h0, hpat[p]}, '0, 6'h3F, 5'(i), 0, 0);
            run(6, i[1], {hpat[(p + 7) % 10], hpat[p]}, '0, 6'h01, 5'(i), 0, 0);
         end

      // R10: clear with no operation
      run(0, 0, 32'h0000_4000, '0, 6'd1, '0, 0, 0);
      chk("R10 vs set", 64'(flag_vs), 64'd1);
      hold_res = result;
      vs_clr = 1'b1;
      @(negedge clk);
      vs_clr = 1'b0;
      exp_vs = 1'b0;
      chk("R10 vs cleared", 64'(flag_vs), 64'd0);
      chk("R11 hold out_valid", 64'(out_valid), 64'd0);
      chk("R11 hold result", 64'(result), 64'(hold_res));
      chk("R11 hold flag_v", 64'(flag_v), 64'd1);
      // R10: clear together with an overflow, set wins
      run(2, 0, 32'h4000_0000, '0, 6'd1, '0, 0, 1);
      chk("R10 set beats clear", 64'(flag_vs), 64'd1);
      // R10: clear together with a quiet shift
      run(2, 0, 32'h0000_0010, '0, 6'd1, '0, 0, 1);
      chk("R10 clear with quiet op", 64'(flag_vs), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule